// File: doc/BRIEF.md
# Match-Capture Timer with PWM

This block is a general purpose 32-bit timer. A 32-bit prescaler divides a stream of count events before they reach the timer. The count events are either every clock cycle or the rising edges of an external count input. The timer value feeds two sets of channels. Four capture channels latch the timer value when their input pin makes a selected transition. Four match channels compare the timer against a programmed value. When the timer enters equality, a match channel can raise an interrupt flag, stop the timer, or reset the timer to zero on its next increment. It can also drive its output pin low, high or to the opposite level. The first three match outputs can be switched to single-edge PWM, with the period set by resetting the timer from the fourth channel. The first two match channels can also emit one-cycle DMA request pulses.

Software sets up the block through a simple single-cycle register bus. Writes take effect at the clock edge, and reads are combinational on a 4-bit word address. For pulse-width measurement, the leading edge on one capture channel clears the timer and prescaler, and a second channel captures the count on the trailing edge.

Top module: `mct_timer`

Register word addresses: 0 control (bit0 run, bit1 count external edges), 1 timer value (read/write), 2 prescale limit, 3 prescale count (read), 4 flags (bits 3:0 match k, bits 7:4 capture k; write 1 to clear), 5 match control, 6 output control, 7 capture control, 8 to 11 match values 0 to 3, 12 to 15 capture values 0 to 3 (read only).

## Requirements
- R1: While running in clock mode with prescale limit P (address 2), the timer advances once every P+1 clock cycles, and it holds its value while control bit0 is 0.
- R2: With control bit1 set, the prescaler advances only on rising edges of `cnt_in`, which is sampled through a two-flop synchronizer. With limit P, the timer advances once per P+1 edges.
- R3: Capture channel k has an edge select in capture control bits [4k+1:4k]: 0 off, 1 rising, 2 falling, 3 both. On a selected edge of `cap_in[k]`, the timer value is loaded into capture register k, three clock edges after the pin changes.
- R4: When capture control bit 4k+3 is set, a capture on channel k clears the timer and the prescale count at the same edge. A pulse of H cycles, with clear on its leading edge and capture on its trailing edge, captures H-1 when the prescale limit is 0.
- R5: When match control bit 3k is set, flag k is set once each time the timer enters equality with match value k. Equality that persists does not set the flag again. When capture control bit 4k+2 is set, flag 4+k is set on each capture of channel k.
- R6: When match control bit 3k+2 is set, entering equality clears control bit0 and the timer holds the match value. This holds even when bit 3k+1 is also set.
- R7: When match control bit 3k+1 is set, the increment that follows equality with match value k loads 0 instead of value+1.
- R8: Flags are sticky and clear only when 1 is written to their bit. `irq` is the OR of all flags.
- R9: Output control bits [2k+1:2k] select the action of match channel k on entering equality: 0 keep, 1 low, 2 high, 3 toggle. The result drives `mat_out[k]`.
- R10: When output control bit 8+k is set (k<3), `mat_out[k]` is high exactly while the timer value is greater than or equal to match value k. A match value of 0 keeps the output high.
- R11: When output control bit 12+k is set (k<2), `dma_req[k]` pulses for one cycle each time match channel k enters equality.
- R12: After reset, every register, the timer and the prescaler are 0, and `mat_out`, `dma_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cnt_in | input | 1 | External count input (asynchronous) |
| cap_in | input | 4 | Capture inputs (asynchronous) |
| mat_out | output | 4 | Match outputs |
| dma_req | output | 2 | One-cycle DMA request pulses |
| irq | output | 1 | Interrupt, OR of all flags |

## Verification
A wrong prescale count or a lost increment shows as a wrong timer readback within one period. It also shifts PWM duty and DMA pulse counts in the very next PWM period. A corrupted equality history shows as a flag that sets again after it was cleared while the timer is stopped, or as a doubled DMA pulse. Both appear within a cycle or two of the clear. Synchronizer or edge-detector faults move captured values by a fixed number of counts, or leave capture registers unchanged, three edges after a pin change.

// File: rtl/mct_pkg.sv
// Shared constants for the match-capture timer: channel count,
// register word addresses and the output action codes.
package mct_pkg;
    localparam int NCH = 4;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_TC   = 4'd1;
    localparam logic [3:0] A_PR   = 4'd2;
    localparam logic [3:0] A_PC   = 4'd3;
    localparam logic [3:0] A_FLAG = 4'd4;
    localparam logic [3:0] A_MCTL = 4'd5;
    localparam logic [3:0] A_OCTL = 4'd6;
    localparam logic [3:0] A_CCTL = 4'd7;
    localparam int OCTL_PWM_LSB = 8;
    localparam int OCTL_DMA_LSB = 12;
    typedef enum logic [1:0] {
        OUT_KEEP = 2'd0,
        OUT_LOW  = 2'd1,
        OUT_HIGH = 2'd2,
        OUT_TOG  = 2'd3
    } out_act_e;
endpackage

// File: rtl/mct_prescale.sv
// Prescaler: counts advance events from 0 up to limit, then issues a
// one-cycle tick and wraps. Assumes clr has priority over counting and
// that a limit lowered below the count wraps at the next advance.
module mct_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         adv,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pc,
    output logic         tick
);
    assign tick = run && adv && (pc >= limit);

    // Advance or wrap the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (clr)        pc <= '0;
        else if (tick)       pc <= '0;
        else if (run && adv) pc <= pc + W'(1);
    end

    // R1
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pc == '0));
endmodule

// File: rtl/mct_capture.sv
// One capture channel: synchronizes the pin through two flops, detects
// the selected edges and loads the timer value. Assumes the pin is
// asynchronous and pulses last at least two clock cycles.
module mct_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic [1:0]   sel,
    input  logic [W-1:0] tc,
    output logic         evt,
    output logic [W-1:0] cap
);
    logic [2:0] sh;
    logic rise, fall;

    assign rise = sh[1] & ~sh[2];
    assign fall = ~sh[1] & sh[2];
    assign evt  = (sel[0] & rise) | (sel[1] & fall);

    // Synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pin};
    end

    // Snapshot the timer on a selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap <= '0;
        else if (evt) cap <= tc;
    end

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cap == $past(tc)));
endmodule

// File: rtl/mct_match.sv
// One match channel: detects entry into equality with the timer and
// drives its pin either from the output action or as a PWM level.
// Assumes the PWM period is set elsewhere by resetting the timer.
module mct_match #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tc,
    input  logic [W-1:0] mr,
    input  logic [1:0]   act,
    input  logic         pwm_en,
    output logic         eq,
    output logic         evt,
    output logic         pin
);
    import mct_pkg::*;
    logic eq_q, ext_q;

    assign eq  = (tc == mr);
    assign evt = eq & ~eq_q;
    assign pin = pwm_en ? (tc >= mr) : ext_q;

    // Remember equality so an event fires only on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    // Apply the output action on a match event.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else if (evt) begin
            case (act)
                OUT_LOW:  ext_q <= 1'b0;
                OUT_HIGH: ext_q <= 1'b1;
                OUT_TOG:  ext_q <= ~ext_q;
                default:  ext_q <= ext_q;
            endcase
        end
    end

    // R5
    match_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    // R9
    out_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act == OUT_TOG) |=> (ext_q != $past(ext_q)));
endmodule

// File: rtl/mct_timer.sv
// Match-capture timer top: register bank, timer counter, count input
// synchronizer, and the wiring of prescaler, capture and match channels.
// Assumes a single-cycle write bus and combinational reads.
module mct_timer #(
    parameter int W    = 32,
    parameter int NPWM = 3,
    parameter int NDMA = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         cnt_in,
    input  logic [3:0]   cap_in,
    output logic [3:0]   mat_out,
    output logic [NDMA-1:0] dma_req,
    output logic         irq
);
    import mct_pkg::*;
    localparam int NFLG = 2 * NCH;

    logic             en_q, cmode_q;
    logic [W-1:0]     tc_q, pr_q, pc;
    logic [3*NCH-1:0] mctl_q;
    logic [2*NCH-1:0] oact_q;
    logic [NPWM-1:0]  pwm_q;
    logic [NDMA-1:0]  dma_q;
    logic [4*NCH-1:0] cctl_q;
    logic [NFLG-1:0]  flags_q;
    logic [W-1:0]     mr_q [NCH];
    logic [W-1:0]     cr   [NCH];
    logic [2:0]       cnt_sh;
    logic [NCH-1:0]   m_eq, m_evt, c_evt, m_irq, m_rst, m_stop, c_irq, c_clr;
    logic             adv, tick, stop_hit, rst_hit, cap_clr, wr_tc;
    logic [W-1:0]     octl_rd;

    assign wr_tc    = bus_wr && bus_addr == A_TC;
    assign adv      = cmode_q ? (cnt_sh[1] & ~cnt_sh[2]) : 1'b1;
    assign stop_hit = |(m_evt & m_stop);
    assign rst_hit  = |(m_eq & m_rst);
    assign cap_clr  = |(c_evt & c_clr);
    assign irq      = |flags_q;

    mct_prescale #(.W(W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en_q & ~stop_hit), .adv(adv),
        .clr(cap_clr | wr_tc), .limit(pr_q), .pc(pc), .tick(tick));

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic pwm_k;
        if (k < NPWM) begin : g_pwm
            assign pwm_k = pwm_q[k];
        end else begin : g_nopwm
            assign pwm_k = 1'b0;
        end
        if (k < NDMA) begin : g_dma
            assign dma_req[k] = m_evt[k] & dma_q[k];
        end
        assign m_irq[k]  = mctl_q[3*k];
        assign m_rst[k]  = mctl_q[3*k+1];
        assign m_stop[k] = mctl_q[3*k+2];
        assign c_irq[k]  = cctl_q[4*k+2];
        assign c_clr[k]  = cctl_q[4*k+3];

        mct_capture #(.W(W)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[k]),
            .sel(cctl_q[4*k +: 2]), .tc(tc_q), .evt(c_evt[k]), .cap(cr[k]));

        mct_match #(.W(W)) u_mat (
            .clk(clk), .rst_n(rst_n), .tc(tc_q), .mr(mr_q[k]),
            .act(oact_q[2*k +: 2]), .pwm_en(pwm_k),
            .eq(m_eq[k]), .evt(m_evt[k]), .pin(mat_out[k]));

        // Match value register write.
        always_ff @(posedge clk) begin
            if (!rst_n) mr_q[k] <= '0;
            else if (bus_wr && bus_addr == 4'(8 + k)) mr_q[k] <= bus_wdata;
        end
    end

    // Synchronize the external count input.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_sh <= '0;
        else        cnt_sh <= {cnt_sh[1:0], cnt_in};
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmode_q <= 1'b0; pr_q <= '0; mctl_q <= '0; oact_q <= '0;
            pwm_q <= '0; dma_q <= '0; cctl_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: cmode_q <= bus_wdata[1];
                A_PR:   pr_q    <= bus_wdata;
                A_MCTL: mctl_q  <= bus_wdata[3*NCH-1:0];
                A_OCTL: begin
                    oact_q <= bus_wdata[2*NCH-1:0];
                    pwm_q  <= bus_wdata[OCTL_PWM_LSB +: NPWM];
                    dma_q  <= bus_wdata[OCTL_DMA_LSB +: NDMA];
                end
                A_CCTL: cctl_q  <= bus_wdata[4*NCH-1:0];
                default: ;
            endcase
        end
    end

    // Run bit: set by software, cleared by a stopping match.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= 1'b0;
        else if (bus_wr && bus_addr == A_CTRL) en_q <= bus_wdata[0];
        else if (stop_hit)                   en_q <= 1'b0;
    end

    // Timer counter: write, capture clear, then increment or match reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       tc_q <= '0;
        else if (wr_tc)   tc_q <= bus_wdata;
        else if (cap_clr) tc_q <= '0;
        else if (tick)    tc_q <= rst_hit ? '0 : tc_q + W'(1);
    end

    // Sticky flags with write-one-to-clear; new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else flags_q <= (flags_q & ~((bus_wr && bus_addr == A_FLAG) ?
                         bus_wdata[NFLG-1:0] : '0)) |
                        {c_evt & c_irq, m_evt & m_irq};
    end

    // Assemble output control readback.
    always_comb begin
        octl_rd = '0;
        octl_rd[2*NCH-1:0] = oact_q;
        octl_rd[OCTL_PWM_LSB +: NPWM] = pwm_q;
        octl_rd[OCTL_DMA_LSB +: NDMA] = dma_q;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {{(W-2){1'b0}}, cmode_q, en_q};
            A_TC:   bus_rdata = tc_q;
            A_PR:   bus_rdata = pr_q;
            A_PC:   bus_rdata = pc;
            A_FLAG: bus_rdata = {{(W-NFLG){1'b0}}, flags_q};
            A_MCTL: bus_rdata = {{(W-3*NCH){1'b0}}, mctl_q};
            A_OCTL: bus_rdata = octl_rd;
            A_CCTL: bus_rdata = {{(W-4*NCH){1'b0}}, cctl_q};
            default: bus_rdata = bus_addr[2] ? cr[bus_addr[1:0]] : mr_q[bus_addr[1:0]];
        endcase
    end

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit && !bus_wr && !cap_clr) |=> (!en_q && tc_q == $past(tc_q)));
    // R7
    match_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rst_hit && !bus_wr && !cap_clr) |=> (tc_q == '0));
    // R4
    cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_clr && !bus_wr) |=> (tc_q == '0 && pc == '0));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: tb/test_mct_timer.sv
module test_mct_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnt_in = 1'b0;
    logic [3:0]  cap_in = '0;
    logic [3:0]  mat_out;
    logic [1:0]  dma_req;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mct_timer i_mct_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
        .cap_in(cap_in), .mat_out(mat_out), .dma_req(dma_req), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd0, v); chk("R12 ctrl", v, 0);
        rd(4'd1, v); chk("R12 timer", v, 0);
        rd(4'd4, v); chk("R12 flags", v, 0);
        chk("R12 pins", {27'd0, irq, dma_req, mat_out[1:0]} | {28'd0, mat_out}, 0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(4'd2, 3);
        wr(4'd0, 1);
        idle(40);
        rd(4'd1, v); chk("R1 limit 3", v, 10);
        wr(4'd0, 0);
        idle(5);
        rd(4'd1, v); chk("R1 hold", v, 10);
        wr(4'd1, 0); wr(4'd2, 0); wr(4'd0, 1);
        idle(10);
        rd(4'd1, v); chk("R1 limit 0", v, 10);
        wr(4'd0, 0);
    endtask

    task automatic t_counter;
        logic [31:0] v;
        wr(4'd1, 0); wr(4'd2, 1); wr(4'd0, 3);
        for (int i = 0; i < 6; i++) begin
            cnt_in = 1'b1; idle(3);
            cnt_in = 1'b0; idle(3);
        end
        idle(5);
        rd(4'd1, v); chk("R2 edges", v, 3);
        idle(10);
        rd(4'd1, v); chk("R2 no edges", v, 3);
        wr(4'd0, 0);
    endtask

    task automatic t_capture;
        logic [31:0] v, v2, c;
        wr(4'd2, 0); wr(4'd1, 0); wr(4'd7, 32'h321); wr(4'd0, 1);
        idle(3);
        rd(4'd1, v); cap_in = 4'b0111;
        idle(6);
        rd(4'd12, c); chk("R3 rise ch0", c, v + 2);
        rd(4'd13, c); chk("R3 fall-only ch1 on rise", c, 0);
        rd(4'd14, c); chk("R3 both ch2 rise", c, v + 2);
        rd(4'd1, v2); cap_in = 4'b1000;
        idle(6);
        rd(4'd12, c); chk("R3 rise-only ch0 on fall", c, v + 2);
        rd(4'd13, c); chk("R3 fall ch1", c, v2 + 2);
        rd(4'd14, c); chk("R3 both ch2 fall", c, v2 + 2);
        rd(4'd15, c); chk("R3 off ch3", c, 0);
        wr(4'd0, 0);
        cap_in = '0; idle(4);
    endtask

    task automatic t_capclr;
        logic [31:0] v;
        wr(4'd7, 32'h29); wr(4'd1, 0); wr(4'd0, 1);
        idle(5);
        cap_in[1:0] = 2'b11; idle(20);
        cap_in[1:0] = 2'b00; idle(6);
        rd(4'd13, v); chk("R4 width", v, 19);
        rd(4'd1, v);  chk("R4 timer cleared", v, 23);
        wr(4'd0, 0);
    endtask

    task automatic t_match_irq;
        logic [31:0] v;
        wr(4'd7, 32'h5000); wr(4'd4, 32'hFF);
        wr(4'd8, 5); wr(4'd9, 8); wr(4'd5, 32'h29);
        wr(4'd2, 0); wr(4'd1, 0); wr(4'd0, 1);
        idle(20);
        rd(4'd1, v); chk("R6 stop value", v, 8);
        rd(4'd0, v); chk("R6 run cleared", v, 0);
        rd(4'd4, v); chk("R5 match flags", v, 3);
        chk("R8 irq high", irq, 1);
        wr(4'd4, 1);
        rd(4'd4, v); chk("R8 selective clear", v, 2);
        wr(4'd4, 2); idle(5);
        rd(4'd4, v); chk("R5 no refire", v, 0);
        chk("R8 irq low", irq, 0);
        cap_in[3] = 1'b1; idle(5);
        rd(4'd4, v); chk("R5 capture flag", v, 32'h80);
        wr(4'd4, 32'h80); cap_in = '0; idle(3);
    endtask

    task automatic t_reset_stop;
        logic [31:0] v, prev, mx;
        int wraps;
        wr(4'd5, 32'h400); wr(4'd11, 9); wr(4'd1, 0); wr(4'd0, 1);
        mx = 0; wraps = 0; prev = 0;
        for (int i = 0; i < 30; i++) begin
            idle(1); rd(4'd1, v);
            if (v > mx) mx = v;
            if (v < prev) wraps++;
            prev = v;
        end
        chk("R7 period max", mx, 9);
        chk("R7 wraps", wraps, 3);
        wr(4'd10, 4); wr(4'd5, 32'h580);
        idle(15);
        rd(4'd1, v); chk("R6 stop beats reset", v, 4);
        rd(4'd0, v); chk("R6 run cleared", v, 0);
    endtask

    task automatic t_outputs;
        logic [31:0] v;
        wr(4'd5, 32'h800);
        wr(4'd8, 2); wr(4'd9, 3); wr(4'd10, 5); wr(4'd11, 9);
        wr(4'd6, 46); wr(4'd1, 0); wr(4'd0, 1);
        idle(15);
        rd(4'd1, v); chk("R9 stopped at 9", v, 9);
        chk("R9 pass one pins", mat_out, 4'b0111);
        wr(4'd6, 30); wr(4'd1, 0); wr(4'd0, 1);
        idle(15);
        chk("R9 pass two pins", mat_out, 4'b0001);
    endtask

    task automatic t_pwm;
        logic [31:0] t;
        int hi0, hi1, hi2, bad1, d0, d1;
        wr(4'd0, 0); wr(4'd5, 32'h400);
        wr(4'd8, 0); wr(4'd9, 4); wr(4'd10, 10); wr(4'd11, 9);
        wr(4'd6, 32'h3700); wr(4'd1, 0); wr(4'd0, 1);
        idle(3);
        hi0 = 0; hi1 = 0; hi2 = 0; bad1 = 0; d0 = 0; d1 = 0;
        for (int i = 0; i < 40; i++) begin
            idle(1); rd(4'd1, t);
            hi0 += mat_out[0]; hi1 += mat_out[1]; hi2 += mat_out[2];
            if (mat_out[1] != (t >= 4)) bad1++;
            d0 += dma_req[0]; d1 += dma_req[1];
        end
        chk("R10 level vs timer", bad1, 0);
        chk("R10 duty ch1", hi1, 24);
        chk("R10 zero value high", hi0, 40);
        chk("R10 above period low", hi2, 0);
        chk("R11 dma ch0 pulses", d0, 4);
        chk("R11 dma ch1 pulses", d1, 4);
        wr(4'd0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_prescale;
        t_counter;
        t_capture;
        t_capclr;
        t_match_irq;
        t_reset_stop;
        t_outputs;
        t_pwm;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule